// File: doc/BRIEF.md
# CPU Memory Write Sequencer

This block sits between the load/store side of a small in-order processor and a plain 32-bit memory bus. When no memory operation is pending, it fetches instructions from the program counter the core presents. When the core raises a request, the block latches it. A load becomes one bus cycle at the data address. The selected byte or halfword lane is returned sign- or zero-extended.

A store to ordinary, unclocked memory (address bit 31 clear) runs a four-cycle frame. First the next instruction is fetched and parked. Then the store address is held with the write strobe high and the byte selects low. Next the byte selects pulse for one cycle. Finally the address is held for one more cycle. A store with address bit 31 set targets clocked memory and takes two cycles: the early fetch, then one strobe cycle with the byte selects active. After either store, the parked instruction is handed to the core in the next fetch cycle, so it is not read again.

Byte and halfword stores replicate their value across the write bus. Lane selection follows big-endian order by default, and a parameter switches it to little-endian. A pause input freezes the sequencer in place.

The states are FETCH, LOAD, NEXT, HOLD_A, STROBE, HOLD_B and FAST. The transitions are:
- FETCH→LOAD on an accepted read.
- FETCH→NEXT on an accepted write.
- NEXT→HOLD_A when bit 31 is clear.
- NEXT→FAST when bit 31 is set.
- HOLD_A→STROBE→HOLD_B→FETCH.
- FAST→FETCH.
- LOAD→FETCH.
- Every state stays put while paused.

Top module: `mem_write_seq`

## Requirements
- R1: After reset the block is in FETCH: `busy`, `mem_we`, `mem_wdata_oe` are 0, `mem_bsel` is 0000 and `instr_valid` is 1.
- R2: In FETCH, `mem_addr` equals `pc_addr` and, unless a parked instruction is pending, `instr_out` equals `mem_rdata`. A request (`req_valid`) is accepted only at a clock edge in FETCH with `pause_in` low.
- R3: A write with address bit 31 clear runs the following cycles after acceptance: NEXT (`mem_addr`=`pc_addr`, `mem_we`=0), then HOLD_A, STROBE and HOLD_B with `mem_addr` = store address and `mem_we`=1. `mem_bsel` is 0000, then the lane mask, then 0000.
- R4: A write with address bit 31 set runs NEXT, then a single FAST cycle with `mem_we`=1 and the lane mask on `mem_bsel`, then returns to FETCH.
- R5: Write data: size 0 (byte) puts `req_wdata[7:0]` on all four lanes, size 1 (halfword) puts `req_wdata[15:0]` on both halves, size 2 or 3 (word) passes all 32 bits. `mem_wdata_oe` is 1 exactly while `mem_we` is 1, and `mem_wdata` is 0 otherwise.
- R6: With `BIG_ENDIAN`=1, byte masks for address low bits 00/01/10/11 are 1000/0100/0010/0001. Halfword masks for address bit 1 = 0/1 are 1100/0011. Word mask is 1111.
- R7: With `BIG_ENDIAN`=0, byte masks for 00/01/10/11 are 0001/0010/0100/1000. Halfword masks for bit 1 = 0/1 are 0011/1100. Load lanes follow the same mapping.
- R8: The word read in NEXT is parked, and the first FETCH cycle after a write presents it on `instr_out` instead of `mem_rdata`.
- R9: While `pause_in` is high the state does not advance, and `mem_addr`, `mem_bsel`, `mem_we`, `mem_wdata` hold their values within a write frame.
- R10: A read takes one LOAD cycle with `mem_addr` = data address and `load_valid`=1. `load_data` is the selected byte (size 0) or halfword (size 1) lane, sign-extended when `req_signed` is 1 and zero-extended otherwise, or the whole word for size 2/3.
- R11: `busy` is 1 in every state except FETCH, and `instr_valid` is 1 only in FETCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pause_in | input | 1 | Freezes the sequencer while high |
| pc_addr | input | 32 | Instruction fetch address from the core |
| req_valid | input | 1 | Memory request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_signed | input | 1 | Sign-extend loaded byte/halfword |
| req_addr | input | 32 | Data address |
| req_wdata | input | 32 | Store data, right-aligned |
| busy | output | 1 | Sequencer away from FETCH |
| instr_out | output | 32 | Fetched or parked instruction |
| instr_valid | output | 1 | `instr_out` is meaningful |
| load_data | output | 32 | Extended load result |
| load_valid | output | 1 | `load_data` is meaningful |
| mem_addr | output | 32 | Bus address |
| mem_wdata | output | 32 | Bus write data |
| mem_wdata_oe | output | 1 | Write data driven |
| mem_rdata | input | 32 | Bus read data |
| mem_bsel | output | 4 | Per-lane byte selects |
| mem_we | output | 1 | Write strobe |

## Verification
On every cycle, the assertions check several properties. The ordering HOLD_A→STROBE→HOLD_B must hold. A fast frame must last one cycle. The address must be stable across the long frame, and byte selects may appear only under the write strobe. Pause must freeze the state and the byte selects, and the parked-instruction flag must be set after each write. Other behaviours can only be shown by the bench's scenarios, which compare every output against a behavioural model on every clock. These are the actual lane masks for each endianness and address, the replicated data patterns, sign and zero extension of loads, and the replay of the parked instruction instead of fresh read data. A pause held inside the strobe cycle must stretch it exactly.

// File: rtl/mws_pkg.sv
package mws_pkg;
    typedef enum logic [2:0] {
        ST_FETCH,
        ST_LOAD,
        ST_NEXT,
        ST_HOLD_A,
        ST_STROBE,
        ST_HOLD_B,
        ST_FAST
    } seq_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/mws_lane_map.sv
module mws_lane_map #(
    parameter int DW         = 32,
    parameter bit BIG_ENDIAN = 1'b1,
    localparam int LANES     = DW / 8,
    localparam int LW        = $clog2(LANES)
) (
    input  logic [1:0]       size,
    input  logic [LW-1:0]    addr_lo,
    input  logic             sext,
    input  logic [DW-1:0]    st_data,
    input  logic [DW-1:0]    rd_data,
    output logic [LANES-1:0] mask,
    output logic [DW-1:0]    wr_bus,
    output logic [DW-1:0]    ld_val
);
    import mws_pkg::*;

    logic [LW-1:0] byte_lane;
    logic [LW-2:0] half_idx;
    logic [7:0]    b_sel;
    logic [15:0]   h_sel;

    always_comb begin
        byte_lane = BIG_ENDIAN ? LW'(LANES - 1) - addr_lo : addr_lo;
        half_idx  = BIG_ENDIAN ? (LW-1)'(LANES/2 - 1) - addr_lo[LW-1:1]
                               : addr_lo[LW-1:1];
        b_sel = rd_data[8*byte_lane +: 8];
        h_sel = rd_data[16*half_idx +: 16];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    mask[i]          = (LW'(i) == byte_lane);
                    wr_bus[8*i +: 8] = st_data[7:0];
                end
                SZ_HALF: begin
                    mask[i]          = ((LW-1)'(i / 2) == half_idx);
                    wr_bus[8*i +: 8] = st_data[8*(i % 2) +: 8];
                end
                default: begin
                    mask[i]          = 1'b1;
                    wr_bus[8*i +: 8] = st_data[8*i +: 8];
                end
            endcase
        end
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: ld_val = {{(DW-8){sext & b_sel[7]}}, b_sel};
            SZ_HALF: ld_val = {{(DW-16){sext & h_sel[15]}}, h_sel};
            default: ld_val = rd_data;
        endcase
    end
endmodule

// File: rtl/mws_seq_fsm.sv
module mws_seq_fsm #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pause_in,
    input  logic [AW-1:0] pc_addr,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    req_size,
    input  logic          req_signed,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_we,
    output logic          strobe_on,
    output logic          busy,
    output logic [DW-1:0] instr_out,
    output logic          instr_valid,
    output logic          load_valid,
    output logic [1:0]    op_size,
    output logic [AW-1:0] op_addr,
    output logic          op_signed,
    output logic [DW-1:0] op_wdata
);
    import mws_pkg::*;

    seq_state_e    state, nxt;
    logic          op_write;
    logic [DW-1:0] parked_op;
    logic          replay;
    logic          accept;

    assign accept = (state == ST_FETCH) && req_valid && !pause_in;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_FETCH:  if (req_valid) nxt = req_write ? ST_NEXT : ST_LOAD;
            ST_LOAD:   nxt = ST_FETCH;
            ST_NEXT:   nxt = op_addr[AW-1] ? ST_FAST : ST_HOLD_A;
            ST_HOLD_A: nxt = ST_STROBE;
            ST_STROBE: nxt = ST_HOLD_B;
            ST_HOLD_B: nxt = ST_FETCH;
            ST_FAST:   nxt = ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)            state <= ST_FETCH;
        else if (!pause_in) state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_write  <= 1'b0;
            op_size   <= '0;
            op_addr   <= '0;
            op_signed <= 1'b0;
            op_wdata  <= '0;
            parked_op <= '0;
            replay    <= 1'b0;
        end else begin
            if (accept) begin
                op_write  <= req_write;
                op_size   <= req_size;
                op_addr   <= req_addr;
                op_signed <= req_signed;
                op_wdata  <= req_wdata;
            end
            if (!pause_in) begin
                if (state == ST_NEXT) parked_op <= mem_rdata;
                if (state == ST_HOLD_B || state == ST_FAST) replay <= 1'b1;
                else if (state == ST_FETCH)                 replay <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_addr    = op_addr;
        bus_we      = 1'b0;
        strobe_on   = 1'b0;
        busy        = 1'b1;
        instr_valid = 1'b0;
        load_valid  = 1'b0;
        instr_out   = parked_op;
        unique case (state)
            ST_FETCH: begin
                bus_addr    = pc_addr;
                busy        = 1'b0;
                instr_valid = 1'b1;
                instr_out   = replay ? parked_op : mem_rdata;
            end
            ST_LOAD:   load_valid = 1'b1;
            ST_NEXT:   bus_addr = pc_addr;
            ST_HOLD_A: bus_we = 1'b1;
            ST_STROBE: begin
                bus_we    = 1'b1;
                strobe_on = 1'b1;
            end
            ST_HOLD_B: bus_we = 1'b1;
            ST_FAST: begin
                bus_we    = 1'b1;
                strobe_on = 1'b1;
            end
            default: busy = 1'b1;
        endcase
    end

    // R3: the long frame advances in fixed order
    p_frame_order_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD_A && !pause_in) |=> (state == ST_STROBE));
    p_frame_tail_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STROBE && !pause_in) |=> (state == ST_HOLD_B));
    // R3: address steady across the long frame
    p_addr_steady_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD_A || state == ST_STROBE) |=> $stable(bus_addr));
    // R4: fast frame lasts one cycle
    p_fast_single_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FAST && !pause_in) |=> (state == ST_FETCH));
    // R9: pause freezes the state
    p_pause_hold_r9: assert property (@(posedge clk) disable iff (rst)
        pause_in |=> $stable(state));
    // R8: parked instruction flagged after every write
    p_replay_set_r8: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_HOLD_B || state == ST_FAST) && !pause_in) |=> replay);
    // R11: op only latched while idle
    p_op_latch_r11: assert property (@(posedge clk) disable iff (rst)
        (state != ST_FETCH) |=> $stable(op_addr));
endmodule

// File: rtl/mem_write_seq.sv
module mem_write_seq #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter bit BIG_ENDIAN = 1'b1,
    localparam int LANES     = DW / 8,
    localparam int LW        = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pause_in,
    input  logic [AW-1:0]    pc_addr,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_size,
    input  logic             req_signed,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             busy,
    output logic [DW-1:0]    instr_out,
    output logic             instr_valid,
    output logic [DW-1:0]    load_data,
    output logic             load_valid,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_wdata_oe,
    input  logic [DW-1:0]    mem_rdata,
    output logic [LANES-1:0] mem_bsel,
    output logic             mem_we
);
    logic             strobe_on;
    logic [1:0]       op_size;
    logic [AW-1:0]    op_addr;
    logic             op_signed;
    logic [DW-1:0]    op_wdata;
    logic [LANES-1:0] lane_mask;
    logic [DW-1:0]    wr_bus;
    logic [DW-1:0]    ld_val;

    mws_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pause_in   (pause_in),
        .pc_addr    (pc_addr),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_signed (req_signed),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_rdata  (mem_rdata),
        .bus_addr   (mem_addr),
        .bus_we     (mem_we),
        .strobe_on  (strobe_on),
        .busy       (busy),
        .instr_out  (instr_out),
        .instr_valid(instr_valid),
        .load_valid (load_valid),
        .op_size    (op_size),
        .op_addr    (op_addr),
        .op_signed  (op_signed),
        .op_wdata   (op_wdata)
    );

    mws_lane_map #(.DW(DW), .BIG_ENDIAN(BIG_ENDIAN)) u_lane (
        .size   (op_size),
        .addr_lo(op_addr[LW-1:0]),
        .sext   (op_signed),
        .st_data(op_wdata),
        .rd_data(mem_rdata),
        .mask   (lane_mask),
        .wr_bus (wr_bus),
        .ld_val (ld_val)
    );

    assign mem_bsel     = strobe_on ? lane_mask : '0;
    assign mem_wdata_oe = mem_we;
    assign mem_wdata    = mem_we ? wr_bus : '0;
    assign load_data    = load_valid ? ld_val : '0;

    // R3: byte selects only inside a write frame
    p_bsel_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_bsel != '0) |-> (mem_we && mem_wdata_oe));
    // R6: a strobe enables 1, 2 or all lanes
    p_lane_count_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_bsel != '0) |-> ($countones(mem_bsel) inside {1, 2, LANES}));
    // R9: paused write frame keeps byte selects and data
    p_pause_bus_r9: assert property (@(posedge clk) disable iff (rst)
        (pause_in && mem_we) |=> ($stable(mem_bsel) && $stable(mem_wdata)));
    // R11: busy and fetch-valid are exclusive
    p_busy_excl_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({busy, instr_valid}) && (busy || instr_valid));
endmodule

// File: tb/mem_write_seq_tb_top.sv
`timescale 1ns/100ps
module mem_write_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pause_in = 1'b0;
    logic [31:0] pc_addr = 32'h0000_0100;
    logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_addr = '0, req_wdata = '0;

    logic        busy, instr_valid, load_valid, mem_wdata_oe, mem_we;
    logic [31:0] instr_out, load_data, mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_bsel;
    logic        busy_le, iv_le, lv_le, oe_le, we_le;
    logic [31:0] instr_le, load_le, addr_le, wdata_le, rdata_le;
    logic [3:0]  bsel_le;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h5A3C_96F1;
    endfunction

    assign mem_rdata = rd(mem_addr);
    assign rdata_le  = rd(addr_le);

    mem_write_seq dut_i (
        .clk(clk), .rst(rst), .pause_in(pause_in), .pc_addr(pc_addr),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_signed(req_signed), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .instr_out(instr_out), .instr_valid(instr_valid),
        .load_data(load_data), .load_valid(load_valid), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
        .mem_rdata(mem_rdata), .mem_bsel(mem_bsel), .mem_we(mem_we));

    mem_write_seq #(.BIG_ENDIAN(1'b0)) dut_le_i (
        .clk(clk), .rst(rst), .pause_in(pause_in), .pc_addr(pc_addr),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_signed(req_signed), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy_le), .instr_out(instr_le), .instr_valid(iv_le),
        .load_data(load_le), .load_valid(lv_le), .mem_addr(addr_le),
        .mem_wdata(wdata_le), .mem_wdata_oe(oe_le),
        .mem_rdata(rdata_le), .mem_bsel(bsel_le), .mem_we(we_le));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------- behavioural reference ----------
    // phase: 0 fetch, 1 load, 2 next, 3 hold_a, 4 strobe, 5 hold_b, 6 fast
    int          ph = 0;
    bit          m_replay = 0;
    logic [31:0] m_parked = '0, m_addr = '0, m_data = '0;
    logic [1:0]  m_size = '0;
    bit          m_sx = 0;

    function automatic logic [3:0] exp_mask(input logic [1:0] sz,
                                            input logic [1:0] lo, input bit big);
        if (sz == 2'd0) return big ? (4'b1000 >> lo) : (4'b0001 << lo);
        if (sz == 2'd1) return (big ^ lo[1]) ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] exp_wdata(input logic [1:0] sz,
                                              input logic [31:0] d);
        if (sz == 2'd0) return {4{d[7:0]}};
        if (sz == 2'd1) return {2{d[15:0]}};
        return d;
    endfunction

    function automatic logic [31:0] exp_load(input logic [1:0] sz,
            input logic [1:0] lo, input bit sx, input logic [31:0] r, input bit big);
        int sh;
        logic [31:0] v;
        if (sz == 2'd0) begin
            sh = big ? 24 - 8*lo : 8*lo;
            v = (r >> sh) & 32'hFF;
            if (sx && v[7]) v = v | 32'hFFFF_FF00;
            return v;
        end
        if (sz == 2'd1) begin
            sh = ((big ? 1 : 0) ^ lo[1]) ? 16 : 0;
            v = (r >> sh) & 32'hFFFF;
            if (sx && v[15]) v = v | 32'hFFFF_0000;
            return v;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; m_replay = 0;
        end else if (!pause_in) begin
            case (ph)
                0: begin
                    m_replay = 0;
                    if (req_valid) begin
                        m_addr = req_addr; m_data = req_wdata;
                        m_size = req_size; m_sx = req_signed;
                        ph = req_write ? 2 : 1;
                    end
                end
                1: ph = 0;
                2: begin m_parked = rd(pc_addr); ph = m_addr[31] ? 6 : 3; end
                3: ph = 4;
                4: ph = 5;
                5: begin ph = 0; m_replay = 1; end
                6: begin ph = 0; m_replay = 1; end
                default: ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            logic [31:0] ea;
            logic        ewe, estr;
            ea   = (ph == 0 || ph == 2) ? pc_addr : m_addr;
            ewe  = (ph >= 3);
            estr = (ph == 4 || ph == 6);
            chk(mem_addr == ea, "R3 mem_addr", mem_addr, ea);
            chk(mem_we == ewe, "R3 mem_we", 32'(mem_we), 32'(ewe));
            chk(mem_bsel == (estr ? exp_mask(m_size, m_addr[1:0], 1) : 4'b0),
                "R6 mem_bsel", 32'(mem_bsel),
                32'(estr ? exp_mask(m_size, m_addr[1:0], 1) : 4'b0));
            chk(bsel_le == (estr ? exp_mask(m_size, m_addr[1:0], 0) : 4'b0),
                "R7 bsel_le", 32'(bsel_le),
                32'(estr ? exp_mask(m_size, m_addr[1:0], 0) : 4'b0));
            chk(mem_wdata_oe == ewe, "R5 oe", 32'(mem_wdata_oe), 32'(ewe));
            chk(mem_wdata == (ewe ? exp_wdata(m_size, m_data) : 32'h0),
                "R5 wdata", mem_wdata, ewe ? exp_wdata(m_size, m_data) : 32'h0);
            chk(busy == (ph != 0), "R11 busy", 32'(busy), 32'(ph != 0));
            chk(instr_valid == (ph == 0), "R11 instr_valid",
                32'(instr_valid), 32'(ph == 0));
            chk(load_valid == (ph == 1), "R10 load_valid",
                32'(load_valid), 32'(ph == 1));
            if (ph == 0)
                chk(instr_out == (m_replay ? m_parked : rd(pc_addr)),
                    m_replay ? "R8 instr replay" : "R2 instr fetch",
                    instr_out, m_replay ? m_parked : rd(pc_addr));
            if (ph == 1) begin
                chk(load_data == exp_load(m_size, m_addr[1:0], m_sx, rd(m_addr), 1),
                    "R10 load_data", load_data,
                    exp_load(m_size, m_addr[1:0], m_sx, rd(m_addr), 1));
                chk(load_le == exp_load(m_size, m_addr[1:0], m_sx, rd(m_addr), 0),
                    "R7 load_le", load_le,
                    exp_load(m_size, m_addr[1:0], m_sx, rd(m_addr), 0));
            end
        end
    end

    // run-length counters for frame shape checks
    int we_cyc = 0, bs_cyc = 0;
    always @(negedge clk) begin
        if (mem_we) we_cyc++;
        if (mem_bsel != 4'b0) bs_cyc++;
    end

    task automatic step();
        @(posedge clk); #1;
        pc_addr = pc_addr + 32'd4;
    endtask

    task automatic op(input bit wr, input logic [1:0] sz, input bit sx,
                      input logic [31:0] a, input logic [31:0] d);
        req_valid = 1; req_write = wr; req_size = sz; req_signed = sx;
        req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 0;
        while (busy) begin @(posedge clk); #1; end
        step();
    endtask

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !mem_we && !mem_wdata_oe && mem_bsel == 4'b0 && instr_valid,
            "R1 reset", {busy, mem_we, mem_wdata_oe, mem_bsel, instr_valid},
            {3'b000, 4'b0000, 1'b1});
        @(posedge clk); #1;
        repeat (3) step();

        // R3 slow stores: every byte lane, halves, word
        for (int i = 0; i < 4; i++) begin
            we_cyc = 0; bs_cyc = 0;
            op(1, 2'd0, 0, 32'h0000_FFFC + 32'(i), 32'h0000_0031 + 32'(i));
            chk(we_cyc == 3, "R3 strobe span", we_cyc, 3);
            chk(bs_cyc == 1, "R3 bsel pulse", bs_cyc, 1);
        end
        op(1, 2'd1, 0, 32'h0000_2000, 32'hBEEF_1234);
        op(1, 2'd1, 0, 32'h0000_2002, 32'hBEEF_5678);
        op(1, 2'd2, 0, 32'h0000_3000, 32'hCAFE_F00D);

        // R4 fast stores
        for (int i = 0; i < 4; i++) begin
            we_cyc = 0; bs_cyc = 0;
            op(1, 2'(i % 3), 0, 32'h8000_1000 + 32'(i), 32'h1357_9BDF);
            chk(we_cyc == 1 && bs_cyc == 1, "R4 fast frame", we_cyc, 1);
        end

        // R10 loads: lanes, signed and unsigned
        for (int i = 0; i < 4; i++) begin
            op(0, 2'd0, 1, 32'h0000_4000 + 32'(i), '0);
            op(0, 2'd0, 0, 32'h0000_4180 + 32'(i), '0);
        end
        op(0, 2'd1, 1, 32'h0000_8000, '0);
        op(0, 2'd1, 0, 32'h0000_0F02, '0);
        op(0, 2'd1, 1, 32'h0000_7FF2, '0);
        op(0, 2'd2, 0, 32'h0000_5004, '0);

        // R9 pause inside strobe stretches it
        we_cyc = 0; bs_cyc = 0;
        req_valid = 1; req_write = 1; req_size = 2'd0; req_addr = 32'h0000_0601;
        req_wdata = 32'h0000_00A5;
        @(posedge clk); #1; req_valid = 0;   // NEXT
        @(posedge clk); #1;                  // HOLD_A
        @(posedge clk); #1;                  // STROBE
        pause_in = 1;
        repeat (3) @(posedge clk);
        #1; pause_in = 0;
        while (busy) begin @(posedge clk); #1; end
        chk(bs_cyc == 4, "R9 paused strobe", bs_cyc, 4);
        chk(we_cyc == 6, "R9 paused frame", we_cyc, 6);

        // R2 request ignored while paused in fetch
        pause_in = 1; req_valid = 1; req_write = 1; req_addr = 32'h0000_0700;
        repeat (2) @(posedge clk);
        #1; req_valid = 0;
        @(negedge clk);
        chk(!busy && !mem_we, "R2 paused accept", 32'(busy), 0);
        #1; pause_in = 0;
        repeat (2) step();

        // back-to-back store then load (R8 replay then fresh op)
        op(1, 2'd2, 0, 32'h0000_0900, 32'h0102_0304);
        op(0, 2'd0, 1, 32'h8000_0003, '0);
        repeat (4) step();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule